// File: doc/BRIEF.md
# Software IRQ Override Unit

This block stands between sixteen external interrupt request lines and the inputs of an interrupt controller. For each line, a per-line select bit decides where the output comes from. With the bit clear, the output follows the external pin after a two-flop synchronizer. With the bit set, the output follows a level held in a register, and the pin has no effect on it.

Software changes the held levels with a masked write. The upper half of the write word chooses which lines are touched, and the lower half gives the new levels for those lines. A level can be written while its line still follows hardware. The stored value is kept and reaches the output as soon as the line is switched to software.

Access is through a simple synchronous register port addressed by byte offset. The select register is at offset 0x1A and the level register at offset 0x1C. A register access is classified as NONE, SELECT or LEVEL. The registers have no sequencing states.

Top module: `sw_irq_override`

## Requirements
- R1: After reset, all select bits and all held levels are 0, `reg_rdata` is 0, and every output follows hardware.
- R2: A write with `reg_addr`=0x1A loads the select bits from `reg_wdata[15:0]`. A read at 0x1A returns them in bits [15:0] with zeros above. Writes to any other offset leave the select bits unchanged.
- R3: While select bit n is 0, `irq_out[n]` equals the value `irq_ext[n]` had two rising clock edges earlier.
- R4: While select bit n is 1, `irq_out[n]` equals held level n, whatever `irq_ext[n]` does.
- R5: A write with `reg_addr`=0x1C sets held level n to `reg_wdata[n]` when `reg_wdata[16+n]` is 1. The new value appears on the output right after that edge if select bit n is 1.
- R6: In a write to 0x1C, held level n keeps its value when `reg_wdata[16+n]` is 0.
- R7: A read at 0x1C returns the held levels in bits [15:0] and zeros in bits [31:16].
- R8: A level written while its select bit is 0 is retained. It drives the output once the select bit is set.
- R9: Writes to offsets other than 0x1A and 0x1C change no state. Reads at such offsets return 0.
- R10: `reg_rdata` takes the read value on the edge where `reg_rd` is 1 and holds that value while `reg_rd` is 0. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte offset within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_ext | input | 16 | External interrupt request lines |
| irq_out | output | 16 | Interrupt request lines to the controller |

## Verification
The external-to-output path takes two edges: a value driven before edge k appears after edge k+1. The bench keeps a two-stage model of this path that it advances on each edge. A register write takes effect on the output right after the edge that accepts it, and read data is due one edge after the strobe. Inputs are driven on the falling edge, and every output is compared at the next falling edge against the model after that model has been advanced for the edge in between.

// File: rtl/irqovr_pkg.sv
package irqovr_pkg;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned HALF_W  = DATA_W / 2;
    localparam logic [ADDR_W-1:0] SEL_OFS = 8'h1A;
    localparam logic [ADDR_W-1:0] LVL_OFS = 8'h1C;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_SELECT = 2'd1,
        ACC_LEVEL  = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        if (ofs == SEL_OFS)      return ACC_SELECT;
        else if (ofs == LVL_OFS) return ACC_LEVEL;
        else                     return ACC_NONE;
    endfunction
endpackage

// File: rtl/irqovr_sync.sv
module irqovr_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/irqovr_regs.sv
module irqovr_regs
    import irqovr_pkg::*;
#(
    parameter int unsigned N_IRQ = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_IRQ-1:0]  sel_q,
    output logic [N_IRQ-1:0]  lvl_q
);
    acc_kind_e        kind;
    logic [N_IRQ-1:0] mask;
    logic [N_IRQ-1:0] vals;
    logic [DATA_W-1:0] rd_word;

    assign kind = decode_ofs(addr);
    assign mask = wdata[HALF_W +: N_IRQ];
    assign vals = wdata[N_IRQ-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr && kind == ACC_SELECT) begin
            sel_q <= vals;
        end
    end

    for (genvar n = 0; n < N_IRQ; n++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[n] <= 1'b0;
            end else if (wr && kind == ACC_LEVEL && mask[n]) begin
                lvl_q[n] <= vals[n];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (kind)
            ACC_SELECT: rd_word[N_IRQ-1:0] = sel_q;
            ACC_LEVEL:  rd_word[N_IRQ-1:0] = lvl_q;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_word;
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == SEL_OFS) |=> $stable(sel_q)); // R2
    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == LVL_OFS) |=> $stable(lvl_q)); // R5
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == LVL_OFS) |=>
        ((lvl_q & ~$past(wdata[HALF_W +: N_IRQ])) ==
         ($past(lvl_q) & ~$past(wdata[HALF_W +: N_IRQ])))); // R6
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (rdata[DATA_W-1:N_IRQ] == '0)); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R10
endmodule

// File: rtl/irqovr_select.sv
module irqovr_select #(
    parameter int unsigned N_IRQ = 16
) (
    input  logic [N_IRQ-1:0] hw_sync,
    input  logic [N_IRQ-1:0] sw_lvl,
    input  logic [N_IRQ-1:0] sel,
    output logic [N_IRQ-1:0] irq_o
);
    for (genvar n = 0; n < N_IRQ; n++) begin : g_mux
        always_comb begin
            unique case (sel[n])
                1'b1:    irq_o[n] = sw_lvl[n];
                default: irq_o[n] = hw_sync[n];
            endcase
        end
    end
endmodule

// File: rtl/sw_irq_override.sv
module sw_irq_override
    import irqovr_pkg::*;
#(
    parameter int unsigned N_IRQ     = 16,
    parameter int unsigned SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_IRQ-1:0]  irq_ext,
    output logic [N_IRQ-1:0]  irq_out
);
    logic [N_IRQ-1:0] hw_sync;
    logic [N_IRQ-1:0] sel_q;
    logic [N_IRQ-1:0] lvl_q;
    logic [1:0]       warm_q;

    irqovr_sync #(.WIDTH(N_IRQ), .STAGES(SYNC_STGS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_ext),
        .d_out (hw_sync)
    );

    irqovr_regs #(.N_IRQ(N_IRQ)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .rd    (reg_rd),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .sel_q (sel_q),
        .lvl_q (lvl_q)
    );

    irqovr_select #(.N_IRQ(N_IRQ)) i_select (
        .hw_sync (hw_sync),
        .sw_lvl  (lvl_q),
        .sel     (sel_q),
        .irq_o   (irq_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)            warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    AST_HW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && SYNC_STGS == 2) |->
        (((irq_out ^ $past(irq_ext, 2)) & ~sel_q) == '0)); // R3
    AST_SW_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        (((irq_out ^ lvl_q) & sel_q) == '0)); // R4
endmodule

// File: tb/test_sw_irq_override.sv
module test_sw_irq_override;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [15:0] irq_ext;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_sel, m_lvl, m_s1, m_s2;
    logic [31:0] m_rdata;

    always #10 clk = ~clk;

    sw_irq_override i_sw_irq_override (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ext(irq_ext), .irq_out(irq_out)
    );

    function automatic logic [15:0] exp_out(logic [15:0] sel, logic [15:0] lvl, logic [15:0] hw);
        return (sel & lvl) | (~sel & hw);
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a, logic [15:0] sel, logic [15:0] lvl);
        if (a == 8'h1A) return {16'h0, sel};
        if (a == 8'h1C) return {16'h0, lvl};
        return 32'h0;
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: inputs applied now (at negedge), model advanced for the edge, outputs checked at next negedge
    task automatic step(logic wr, logic rd, logic [7:0] a, logic [31:0] wd, logic [15:0] ext);
        logic [15:0] eo;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; irq_ext = ext;
        @(posedge clk);
        if (rd) m_rdata = exp_read(a, m_sel, m_lvl);
        m_s2 = m_s1; m_s1 = ext;
        if (wr && a == 8'h1A) m_sel = wd[15:0];
        if (wr && a == 8'h1C) m_lvl = (m_lvl & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
        @(negedge clk);
        eo = exp_out(m_sel, m_lvl, m_s2);
        if (((irq_out ^ eo) & m_sel) != 16'h0) check32("R4", {16'h0, irq_out}, {16'h0, eo});
        else check32("R3", {16'h0, irq_out}, {16'h0, eo});
        check32("R10", reg_rdata, m_rdata);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7331));
        rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; irq_ext = 16'hFFFF;
        m_sel = 0; m_lvl = 0; m_s1 = 0; m_s2 = 0; m_rdata = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check32("R1", reg_rdata, 32'h0);
        check32("R1", {16'h0, irq_out}, 32'h0);
        rst_n = 1'b1;
        step(0, 1, 8'h1A, 0, 16'h0);
        check32("R1", reg_rdata, 32'h0);
        step(0, 0, 8'h00, 0, 16'hA5A5);
        step(0, 0, 8'h00, 0, 16'hA5A5);
        check32("R3", {16'h0, irq_out}, 32'h0000A5A5);
        // R8: write levels while lines follow hardware
        step(1, 0, 8'h1C, 32'hFFFF_0F0F, 16'h0000);
        step(0, 0, 8'h00, 0, 16'h0000);
        check32("R8", {16'h0, irq_out}, 32'h0);
        step(1, 0, 8'h1A, 32'h0000_00FF, 16'h0000);
        check32("R8", {16'h0, irq_out}, 32'h0000_000F);
        // R4: hardware ignored on software lines
        step(0, 0, 8'h00, 0, 16'hFFFF);
        step(0, 0, 8'h00, 0, 16'hFFFF);
        check32("R4", {16'h0, irq_out}, 32'h0000_FF0F);
        // R6: mask clear keeps levels, R5: masked bit changes
        step(1, 0, 8'h1C, 32'h0001_FFF0, 16'hFFFF);
        step(0, 1, 8'h1C, 0, 16'hFFFF);
        check32("R6", reg_rdata, 32'h0000_0F0E);
        check32("R7", reg_rdata[31:16] == 16'h0 ? 32'h0 : 32'h1, 32'h0);
        // R2: select readback
        step(0, 1, 8'h1A, 0, 16'hFFFF);
        check32("R2", reg_rdata, 32'h0000_00FF);
        // R9: other offsets
        step(1, 0, 8'h1B, 32'hFFFF_FFFF, 16'hFFFF);
        step(1, 1, 8'h18, 32'hFFFF_FFFF, 16'hFFFF);
        check32("R9", reg_rdata, 32'h0);
        step(0, 1, 8'h1C, 0, 16'hFFFF);
        check32("R9", reg_rdata, 32'h0000_0F0E);
        // R10: read coincident with write returns old value
        step(1, 1, 8'h1A, 32'h0000_1234, 16'h0);
        check32("R10", reg_rdata, 32'h0000_00FF);
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            int pick;
            pick = $urandom_range(0, 9);
            a = (pick < 4) ? 8'h1C : (pick < 7) ? 8'h1A : 8'($urandom);
            step(1'($urandom), 1'($urandom), a, $urandom, 16'($urandom));
        end
        finish_run();
    end
endmodule